// File: doc/BRIEF.md
# Relative Interval Alarm

This block is a one-shot alarm that runs down a relative interval. Software writes a packed interval of days, hours, minutes and seconds. On every one-second tick, while the countdown is enabled, the remaining count drops by one second. Borrows pass from seconds to minutes, then to hours, then to days.

When the count goes from one second to zero, a sticky pending flag is set. The count then stays at zero until software writes a new interval. The interrupt line is high while the pending flag is set and the interrupt is enabled. Software clears the flag by writing a one to it.

All access goes through a 32-bit register bus with single-cycle writes. Reads are combinational and return the value for the current address.

Top module: `alarm_cd_top`

## Requirements
- R1: The interval register (address 0x0C) packs seconds into bits [5:0], minutes into [13:8], hours into [20:16] and days (0 to 255) into [28:21]. A read returns the remaining count in this same layout, and all other bits read as zero.
- R2: A `tick_i` pulse while the countdown is enabled and the count is non-zero lowers the count by one second. A seconds field of 0 borrows and becomes 59, a minutes field of 0 becomes 59, an hours field of 0 becomes 23, and the borrow then lowers the day field.
- R3: While the enable bit is 0, ticks leave the count unchanged and no pending event is raised.
- R4: Writing zero to the interval register clears any countdown in progress, and no event follows.
- R5: The tick that takes the count from one second to zero sets the pending flag (status register 0x1C, bit 0) in the same clock edge. The count then holds at zero, and further ticks raise no new event until the interval is written again.
- R6: Writing 1 to status bit 0 clears the pending flag. Writing 0 there leaves the flag unchanged.
- R7: `irq_o` is a level that is high exactly while the pending flag and interrupt-enable bit 0 (register 0x18) are both 1.
- R8: After reset, every register reads zero and `irq_o` is low.
- R9: The enable register (0x14) keeps only bit 8, and the interrupt-enable register (0x18) keeps only bit 0. Both read back at those positions with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse once per second |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| irq_o | output | 1 | Level interrupt |

## Verification
The checker watches every cycle for the following:
- a pending event appears only on an enabled tick, coming from a count of exactly one second;
- a zero count stays at zero;
- a disabled countdown keeps its count unchanged;
- the pending flag survives every cycle that carries no clear write;
- the interrupt level is gated by both of its sources.

Some properties need a whole scenario, and only the bench's runs can show them. These are the borrow chain across each field boundary, the exact readback layout including the ignored gap bits, the one-shot behaviour after a clear, and the interrupt toggling as its enable changes.

// File: rtl/alarm_cd_pkg.sv
package alarm_cd_pkg;
  parameter int SEC_W = 6;
  parameter int MIN_W = 6;
  parameter int HR_W  = 5;
  parameter int DAY_W = 8;

  parameter int SEC_LSB = 0;
  parameter int MIN_LSB = 8;
  parameter int HR_LSB  = 16;
  parameter int DAY_LSB = 21;

  parameter int SEC_MAX = 59;
  parameter int MIN_MAX = 59;
  parameter int HR_MAX  = 23;

  parameter int OFF_IVL  = 'h0C;
  parameter int OFF_EN   = 'h14;
  parameter int OFF_IE   = 'h18;
  parameter int OFF_STAT = 'h1C;
  parameter int EN_BIT   = 8;
  parameter int IE_BIT   = 0;
  parameter int PEND_BIT = 0;

  typedef struct packed {
    logic [DAY_W-1:0] day;
    logic [HR_W-1:0]  hr;
    logic [MIN_W-1:0] min;
    logic [SEC_W-1:0] sec;
  } ivl_t;

  function automatic logic [31:0] ivl_to_word(ivl_t v);
    logic [31:0] w;
    w = '0;
    w[SEC_LSB +: SEC_W] = v.sec;
    w[MIN_LSB +: MIN_W] = v.min;
    w[HR_LSB  +: HR_W]  = v.hr;
    w[DAY_LSB +: DAY_W] = v.day;
    return w;
  endfunction

  function automatic ivl_t word_to_ivl(logic [31:0] w);
    ivl_t v;
    v.sec = w[SEC_LSB +: SEC_W];
    v.min = w[MIN_LSB +: MIN_W];
    v.hr  = w[HR_LSB  +: HR_W];
    v.day = w[DAY_LSB +: DAY_W];
    return v;
  endfunction
endpackage

// File: rtl/alarm_cd_counter.sv
module alarm_cd_counter
  import alarm_cd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  ivl_t load_val_i,
  input  logic step_i,
  output ivl_t cnt_o,
  output logic expire_o
);
  ivl_t cnt_q, cnt_dec;
  logic is_zero, is_last;

  assign is_zero = (cnt_q == '0);
  assign is_last = (cnt_q.day == '0) && (cnt_q.hr == '0) &&
                   (cnt_q.min == '0) && (cnt_q.sec == SEC_W'(1));

  always_comb begin
    cnt_dec = cnt_q;
    if (cnt_q.sec != '0) begin
      cnt_dec.sec = cnt_q.sec - SEC_W'(1);
    end else begin
      cnt_dec.sec = SEC_W'(SEC_MAX);
      if (cnt_q.min != '0) begin
        cnt_dec.min = cnt_q.min - MIN_W'(1);
      end else begin
        cnt_dec.min = MIN_W'(MIN_MAX);
        if (cnt_q.hr != '0) begin
          cnt_dec.hr = cnt_q.hr - HR_W'(1);
        end else begin
          cnt_dec.hr  = HR_W'(HR_MAX);
          cnt_dec.day = cnt_q.day - DAY_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i)              cnt_q <= load_val_i;
    else if (step_i && !is_zero)  cnt_q <= cnt_dec;
  end

  // load takes priority over a coincident final tick
  assign expire_o = step_i && is_last && !load_i;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/alarm_cd_regs.sv
module alarm_cd_regs
  import alarm_cd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  ivl_t              cnt_i,
  input  logic              expire_i,
  output logic              en_o,
  output logic              ie_o,
  output logic              pend_o,
  output logic              load_o,
  output ivl_t              load_val_o,
  output logic [31:0]       rdata_o
);
  localparam logic [ADDR_W-1:0] A_IVL  = ADDR_W'(OFF_IVL);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFF_EN);
  localparam logic [ADDR_W-1:0] A_IE   = ADDR_W'(OFF_IE);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);

  logic en_q, ie_q, pend_q, clr;

  assign load_o     = we_i && (addr_i == A_IVL);
  assign load_val_o = word_to_ivl(wdata_i);
  assign clr        = we_i && (addr_i == A_STAT) && wdata_i[PEND_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (we_i && addr_i == A_EN) en_q <= wdata_i[EN_BIT];
      if (we_i && addr_i == A_IE) ie_q <= wdata_i[IE_BIT];
      // a new event wins over a simultaneous clear
      if (expire_i)  pend_q <= 1'b1;
      else if (clr)  pend_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_IVL:  rdata_o = ivl_to_word(cnt_i);
      A_EN:   rdata_o[EN_BIT]   = en_q;
      A_IE:   rdata_o[IE_BIT]   = ie_q;
      A_STAT: rdata_o[PEND_BIT] = pend_q;
      default: rdata_o = '0;
    endcase
  end

  assign en_o   = en_q;
  assign ie_o   = ie_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/alarm_cd_top.sv
module alarm_cd_top
  import alarm_cd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o
);
  ivl_t cnt, load_val;
  logic en, ie, pend, load, expire;

  alarm_cd_counter u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .step_i     (tick_i && en),
    .cnt_o      (cnt),
    .expire_o   (expire)
  );

  alarm_cd_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .cnt_i      (cnt),
    .expire_i   (expire),
    .en_o       (en),
    .ie_o       (ie),
    .pend_o     (pend),
    .load_o     (load),
    .load_val_o (load_val),
    .rdata_o    (reg_rdata_o)
  );

  assign irq_o = pend && ie;
endmodule

// File: rtl/alarm_cd_checker.sv
module alarm_cd_checker
  import alarm_cd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic              irq_o,
  input ivl_t              cnt,
  input logic              en,
  input logic              ie,
  input logic              pend
);
  logic wr_ivl, wr_clr;
  assign wr_ivl = reg_we_i && reg_addr_i == ADDR_W'(OFF_IVL);
  assign wr_clr = reg_we_i && reg_addr_i == ADDR_W'(OFF_STAT) && reg_wdata_i[PEND_BIT];

  AST_EVENT_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend) |-> $past(en && tick_i)); // R3
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !wr_ivl) |=> $stable(cnt)); // R3
  AST_ZERO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ivl && word_to_ivl(reg_wdata_i) == '0) |=> (cnt == '0)); // R4
  AST_LAST_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend) |-> (cnt == '0 && $past(ivl_to_word(cnt)) == 32'd1)); // R5
  AST_STAY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0 && !wr_ivl) |=> (cnt == '0)); // R5
  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && !wr_clr) |=> pend); // R6
  AST_IRQ_SOURCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend && ie)); // R7
endmodule

bind alarm_cd_top alarm_cd_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .irq_o       (irq_o),
  .cnt         (cnt),
  .en          (en),
  .ie          (ie),
  .pend        (pend)
);

// File: tb/alarm_cd_top_test.sv
module alarm_cd_top_test;
  localparam int ADDR_W = 8;
  localparam logic [7:0] A_IVL = 8'h0C, A_EN = 8'h14, A_IE = 8'h18, A_STAT = 8'h1C;
  localparam int NV = 5;
  // interval written, ticks applied, remaining count expected (R2)
  localparam logic [31:0] V_IN  [NV] = '{32'h0000_0005, 32'h0000_0100, 32'h0001_0000,
                                         32'h0020_0000, 32'h0043_0405};
  localparam int          V_TK  [NV] = '{3, 1, 1, 1, 10};
  localparam logic [31:0] V_EXP [NV] = '{32'h0000_0002, 32'h0000_003B, 32'h0000_3B3B,
                                         32'h0017_3B3B, 32'h0043_0337};

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  alarm_cd_top #(.ADDR_W(ADDR_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8 reset state
    rd(A_IVL, r);  check("R8 interval", r, 32'h0);
    rd(A_EN, r);   check("R8 enable", r, 32'h0);
    rd(A_IE, r);   check("R8 irq enable", r, 32'h0);
    rd(A_STAT, r); check("R8 status", r, 32'h0);
    check("R8 irq", {31'b0, irq}, 32'h0);
    // R9 control bit positions
    wr(A_EN, 32'hFFFF_FFFF); rd(A_EN, r); check("R9 enable bit8", r, 32'h0000_0100);
    wr(A_IE, 32'hFFFF_FFFF); rd(A_IE, r); check("R9 ie bit0", r, 32'h0000_0001);
    wr(A_IE, 32'h0);
    // R2 table walk
    for (int i = 0; i < NV; i++) begin
      wr(A_IVL, V_IN[i]);
      ticks(V_TK[i]);
      rd(A_IVL, r); check("R2 borrow chain", r, V_EXP[i]);
    end
    // R1 layout and readback
    wr(A_IVL, 32'h1FF7_3B3B); rd(A_IVL, r); check("R1 full fields", r, 32'h1FF7_3B3B);
    wr(A_IVL, 32'hFFFF_FFFF); rd(A_IVL, r); check("R1 gap bits", r, 32'h1FFF_3F3F);
    // R4 zero write clears countdown
    wr(A_IVL, 32'h0000_0010); ticks(2);
    wr(A_IVL, 32'h0); rd(A_IVL, r); check("R4 cleared", r, 32'h0);
    ticks(3); rd(A_STAT, r); check("R4 no event", r, 32'h0);
    // R3 disabled
    wr(A_EN, 32'h0); wr(A_IVL, 32'h0000_0003); ticks(5);
    rd(A_IVL, r);  check("R3 frozen", r, 32'h0000_0003);
    rd(A_STAT, r); check("R3 no pending", r, 32'h0);
    wr(A_EN, 32'h0000_0100);
    // R5 expiry
    wr(A_IE, 32'h1); ticks(2);
    rd(A_IVL, r);  check("R5 one left", r, 32'h0000_0001);
    rd(A_STAT, r); check("R5 not yet", r, 32'h0);
    check("R7 irq low", {31'b0, irq}, 32'h0);
    ticks(1);
    rd(A_STAT, r); check("R5 pending set", r, 32'h1);
    rd(A_IVL, r);  check("R5 count zero", r, 32'h0);
    check("R7 irq high", {31'b0, irq}, 32'h1);
    ticks(3); rd(A_IVL, r); check("R5 holds zero", r, 32'h0);
    // R6 / R7
    wr(A_STAT, 32'h0); rd(A_STAT, r); check("R6 write0 keeps", r, 32'h1);
    wr(A_IE, 32'h0); check("R7 gated off", {31'b0, irq}, 32'h0);
    rd(A_STAT, r); check("R7 pending kept", r, 32'h1);
    wr(A_IE, 32'h1); check("R7 level back", {31'b0, irq}, 32'h1);
    wr(A_STAT, 32'h1); rd(A_STAT, r); check("R6 w1c", r, 32'h0);
    check("R7 irq cleared", {31'b0, irq}, 32'h0);
    ticks(3); rd(A_STAT, r); check("R5 one shot", r, 32'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule